// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Controller

This block is the front end of a small dynamic memory model with a 4-bit data path. It samples the row strobe, column strobe and write strobe on every clock edge and works out from their order what kind of access cycle is running. There are four kinds: an ordinary read or write cycle, a refresh where only the row strobe toggles, a refresh where the column strobe falls before the row strobe, and that same early-column cycle with the write strobe held low. The last kind switches the device into a parallel test mode.

In test mode the array is treated as half its normal depth. A write takes a single bit from the lowest data lane and stores it in eight cells at once: all four lanes of the two columns that differ only in column bit 0. A read compares those eight cells and reports one pass or fail value on every data output instead of the stored data. A refresh cycle of either kind with the write strobe high returns the device to normal operation.

After power-up the block ignores accesses until a set number of cycles has completed, with at least one refresh among them. A status output shows when this initialisation is over.

Top module: `dram_dft_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `dq_valid` is 0, `dq_out` is 0 and `init_done` is 0.
- R2: `init_done` goes to 1 at the end (row strobe rising) of the INIT_CYCLES-th (default 8) completed cycle if at least one cycle so far was a refresh. Otherwise it goes to 1 at the end of the first refresh cycle after that. Once it is 1 it stays 1 until reset.
- R3: A cycle that started while `init_done` was 0 changes no stored data and never sets `dq_valid`.
- R4: A cycle starts when `ras_n` falls with `cas_n` high, and the row is taken from `addr` at that edge. The column is taken from `addr` when `cas_n` falls. With `we_n` low and `cas_n` low, `dq_in` is stored at (row, column). With `cas_n`, `oe_n` low and `we_n` high, the cell is read: one clock later `dq_valid` is 1 and `dq_out` holds the stored nibble. In every other case `dq_valid` and `dq_out` are 0.
- R5: Within one row-strobe-low period, each new fall of `cas_n` latches a new column (page mode), and reads and writes go to that column.
- R6: A read followed by a write within the same column-strobe-low period (read-modify-write) returns the old data and then stores the new data.
- R7: A cycle with `cas_n` already low when `ras_n` falls and `we_n` low enters test mode once `init_done` is 1. It stores nothing, and its `addr` is ignored.
- R8: In test mode, a write stores `dq_in[0]` into all 4 bits of both columns whose addresses differ only in bit 0, giving eight cells in total.
- R9: In test mode, a read gives `dq_out` = 4'hF if the eight cells of the addressed column pair are all equal and 4'h0 otherwise, with `dq_valid` = 1.
- R10: A cycle in which only the row strobe toggles, or a cycle with `cas_n` low at the `ras_n` fall and `we_n` high, leaves test mode. Later reads then return stored nibbles again.
- R11: A cycle with `cas_n` low at the `ras_n` fall and `we_n` high is a refresh. It steps an internal refresh row counter by one when it ends, ignores `addr` and leaves all stored data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset (data array is not cleared) |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| dq_in | input | DQ_W | Write data; bit 0 is the test-mode data lane |
| dq_out | output | DQ_W | Read data or compressed pass/fail |
| dq_valid | output | 1 | Read data on dq_out is valid |
| init_done | output | 1 | Initialisation sequence complete |

## Verification
Most internal faults in this block show up in the first read that follows them. A wrong cycle classification or a stuck test-mode flag makes the next read return a compressed 4'hF/4'h0 in place of the stored nibble, or the reverse, one clock after the column strobe falls. A bad write mask or a wrong column latch becomes visible when the neighbouring column of the pair is read back, and a miscounting initialisation tracker shows on `init_done` at the end of the cycle in question. The directed scenarios therefore read back both columns of a pair after every test-mode or refresh cycle.

// File: rtl/dram_dft_pkg.sv
package dram_dft_pkg;

    // Where the controller is within one row-strobe period
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // row strobe high, waiting for a cycle
        PH_ROW  = 2'd1,  // row latched, no column strobe yet
        PH_ACC  = 2'd2,  // column strobe seen, access phase
        PH_CBR  = 2'd3   // column-first refresh cycle running
    } phase_e;

endpackage

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall
);

    typedef struct packed {
        logic ras;
        logic cas;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.ras = ras_n;
        prev_d.cas = cas_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{ras: 1'b1, cas: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    assign ras_fall = prev_q.ras & ~ras_n;
    assign ras_rise = ~prev_q.ras & ras_n;
    assign cas_fall = prev_q.cas & ~cas_n;

endmodule

// File: rtl/dram_init_tracker.sv
module dram_init_tracker #(
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_end,
    input  logic cyc_refresh,
    output logic done
);

    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INIT_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen_ref;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (cyc_end) begin
            if (trk_q.cnt != CNT_MAX) begin
                trk_d.cnt = trk_q.cnt + 1'b1;
            end
            if (cyc_refresh) begin
                trk_d.seen_ref = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign done = (trk_q.cnt == CNT_MAX) & trk_q.seen_ref;

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int ADDR_W = 4,
    parameter int DQ_W   = 4
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [ADDR_W-1:0]     wr_row,
    input  logic [ADDR_W-2:0]     wr_pair,
    input  logic [DQ_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]     rd_row,
    input  logic [ADDR_W-2:0]     rd_pair,
    output logic [2*DQ_W-1:0]     rd_data
);

    // One entry holds an even/odd column pair: low lane even, high lane odd
    localparam int IDX_W = 2 * ADDR_W - 1;
    localparam int DEPTH = 2 ** IDX_W;

    logic [2*DQ_W-1:0] cells [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx = {wr_row, wr_pair};
    assign rd_idx = {rd_row, rd_pair};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_lo) begin
                cells[wr_idx][DQ_W-1:0] <= wr_data;
            end
            if (wr_hi) begin
                cells[wr_idx][2*DQ_W-1:DQ_W] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/dram_test_compress.sv
module dram_test_compress #(
    parameter int DQ_W = 4
) (
    input  logic [2*DQ_W-1:0] pair_data,
    input  logic              col_lsb,
    input  logic              test_on,
    output logic [DQ_W-1:0]   rd_out
);

    logic all_same;

    assign all_same = (&pair_data) | ~(|pair_data);

    always_comb begin
        if (test_on) begin
            rd_out = all_same ? '1 : '0;
        end else if (col_lsb) begin
            rd_out = pair_data[2*DQ_W-1:DQ_W];
        end else begin
            rd_out = pair_data[DQ_W-1:0];
        end
    end

endmodule

// File: rtl/dram_dft_ctrl.sv
module dram_dft_ctrl
    import dram_dft_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DQ_W        = 4,
    parameter int INIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_valid,
    output logic              init_done
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic              ok;       // cycle began after initialisation
        logic              test;     // parallel test mode active
        logic [ADDR_W-1:0] ref_row;  // internal refresh row counter
        logic              valid;
        logic [DQ_W-1:0]   dout;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic              ras_fall, ras_rise, cas_fall;
    logic              cyc_end, cyc_refresh;
    logic              acc_now, rd_now, mem_wr;
    logic              wr_lo, wr_hi;
    logic [DQ_W-1:0]   wr_data;
    logic [ADDR_W-1:0] col_eff;
    logic [2*DQ_W-1:0] pair_data;
    logic [DQ_W-1:0]   cmp_out;

    // Plain views of state for the bound checker
    logic              test_on;
    phase_e            phase_now;
    logic [ADDR_W-1:0] ref_row_now;

    dram_strobe_decode i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall)
    );

    dram_init_tracker #(.INIT_CYCLES(INIT_CYCLES)) i_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_end     (cyc_end),
        .cyc_refresh (cyc_refresh),
        .done        (init_done)
    );

    dram_cell_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) i_array (
        .clk     (clk),
        .wr_en   (mem_wr),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_row  (st_q.row),
        .wr_pair (col_eff[ADDR_W-1:1]),
        .wr_data (wr_data),
        .rd_row  (st_q.row),
        .rd_pair (col_eff[ADDR_W-1:1]),
        .rd_data (pair_data)
    );

    dram_test_compress #(.DQ_W(DQ_W)) i_compress (
        .pair_data (pair_data),
        .col_lsb   (col_eff[0]),
        .test_on   (st_q.test),
        .rd_out    (cmp_out)
    );

    always_comb begin
        st_d        = st_q;
        cyc_end     = 1'b0;
        cyc_refresh = 1'b0;
        acc_now     = 1'b0;
        col_eff     = cas_fall ? addr : st_q.col;

        case (st_q.phase)
            PH_IDLE: begin
                if (ras_fall) begin
                    if (!cas_n) begin
                        // column strobe first: refresh, write strobe picks test entry
                        st_d.phase = PH_CBR;
                        st_d.test  = init_done & ~we_n;
                    end else begin
                        st_d.phase = PH_ROW;
                        st_d.row   = addr;
                        st_d.ok    = init_done;
                    end
                end
            end
            PH_ROW: begin
                if (ras_rise) begin
                    // no column strobe seen: row-only refresh
                    st_d.phase  = PH_IDLE;
                    st_d.test   = 1'b0;
                    cyc_end     = 1'b1;
                    cyc_refresh = 1'b1;
                end else if (cas_fall) begin
                    st_d.phase = PH_ACC;
                    st_d.col   = addr;
                    acc_now    = 1'b1;
                end
            end
            PH_ACC: begin
                if (ras_rise) begin
                    st_d.phase = PH_IDLE;
                    cyc_end    = 1'b1;
                end else if (!cas_n) begin
                    acc_now = 1'b1;
                    if (cas_fall) begin
                        st_d.col = addr;
                    end
                end
            end
            PH_CBR: begin
                if (ras_rise) begin
                    st_d.phase   = PH_IDLE;
                    st_d.ref_row = st_q.ref_row + 1'b1;
                    cyc_end      = 1'b1;
                    cyc_refresh  = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase

        mem_wr  = acc_now & st_q.ok & ~we_n;
        rd_now  = acc_now & st_q.ok & we_n & ~oe_n;
        wr_lo   = st_q.test | ~col_eff[0];
        wr_hi   = st_q.test | col_eff[0];
        wr_data = st_q.test ? {DQ_W{dq_in[0]}} : dq_in;

        st_d.valid = rd_now;
        st_d.dout  = rd_now ? cmp_out : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out      = st_q.dout;
    assign dq_valid    = st_q.valid;
    assign test_on     = st_q.test;
    assign phase_now   = st_q.phase;
    assign ref_row_now = st_q.ref_row;

endmodule

// File: rtl/dram_dft_ctrl_chk.sv
module dram_dft_ctrl_chk
    import dram_dft_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DQ_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [DQ_W-1:0]   dq_out,
    input logic              dq_valid,
    input logic              init_done,
    input logic              test_on,
    input phase_e            phase_now,
    input logic [ADDR_W-1:0] ref_row_now,
    input logic              mem_wr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // R3
    valid_needs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> init_done);

    // R2
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R4
    valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> $past(!cas_n && !oe_n && we_n));

    // R9
    test_read_compressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && $past(test_on)) |-> (dq_out == '0 || dq_out == '1));

    // R11
    refresh_row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_now == PH_CBR && ras_n) |=> (ref_row_now == $past(ref_row_now) + STEP));

    // R7
    no_write_in_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_now == PH_CBR) |-> !mem_wr);

endmodule

bind dram_dft_ctrl dram_dft_ctrl_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .dq_out      (dq_out),
    .dq_valid    (dq_valid),
    .init_done   (init_done),
    .test_on     (test_on),
    .phase_now   (phase_now),
    .ref_row_now (ref_row_now),
    .mem_wr      (mem_wr)
);

// File: tb/test_dram_dft_ctrl.sv
module test_dram_dft_ctrl;

    localparam int ADDR_W = 4;
    localparam int DQ_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ras_n, cas_n, we_n, oe_n;
    logic [ADDR_W-1:0] addr;
    logic [DQ_W-1:0]   dq_in;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_valid;
    logic              init_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dram_dft_ctrl #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .INIT_CYCLES(8)) i_dram_dft_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_valid  (dq_valid),
        .init_done (init_done)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq_in = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic ras_open(input logic [ADDR_W-1:0] row);
        addr = row; ras_n = 1'b0;
        tick();
    endtask

    task automatic ras_close();
        ras_n = 1'b1;
        tick();
        tick();
    endtask

    task automatic cas_wr(input logic [ADDR_W-1:0] col, input logic [DQ_W-1:0] d);
        addr = col; dq_in = d; we_n = 1'b0; cas_n = 1'b0;
        tick();
        cas_n = 1'b1; we_n = 1'b1;
        tick();
    endtask

    task automatic cas_rd(input logic [ADDR_W-1:0] col, input logic expv,
                          input logic [DQ_W-1:0] expd, input string req);
        addr = col; oe_n = 1'b0; cas_n = 1'b0;
        tick();
        chk(req, "read valid", 8'(dq_valid), 8'(expv));
        chk(req, "read data", 8'(dq_out), 8'(expv ? expd : 4'h0));
        cas_n = 1'b1; oe_n = 1'b1;
        tick();
        chk("R4", "valid after column strobe high", 8'({dq_valid, dq_out}), 8'h00);
    endtask

    task automatic wr_cycle(input logic [ADDR_W-1:0] row, input logic [ADDR_W-1:0] col,
                            input logic [DQ_W-1:0] d);
        ras_open(row);
        cas_wr(col, d);
        ras_close();
    endtask

    task automatic rd_cycle(input logic [ADDR_W-1:0] row, input logic [ADDR_W-1:0] col,
                            input logic expv, input logic [DQ_W-1:0] expd, input string req);
        ras_open(row);
        cas_rd(col, expv, expd, req);
        ras_close();
    endtask

    task automatic ras_only(input logic [ADDR_W-1:0] row);
        ras_open(row);
        ras_close();
    endtask

    task automatic cbr(input logic we, input logic [ADDR_W-1:0] junk_addr);
        cas_n = 1'b0;
        tick();
        addr = junk_addr; we_n = we; ras_n = 1'b0;
        tick();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        tick();
        tick();
    endtask

    // Cells are not cleared by reset, so bring the array to init state
    task automatic bring_up();
        do_reset();
        repeat (7) ras_only(4'h0);
        ras_only(4'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq_in = '0;
        tick();
        chk("R1", "valid in reset", 8'(dq_valid), 8'h0);
        chk("R1", "init in reset", 8'(init_done), 8'h0);
        rst_n = 1'b1;
        tick();
        chk("R1", "dq_out after reset", 8'(dq_out), 8'h0);
        chk("R1", "init after reset", 8'(init_done), 8'h0);
    endtask

    task automatic t_init_no_refresh();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            rd_cycle(4'h1, 4'h1, 1'b0, 4'h0, "R3");
        end
        chk("R2", "init after 8 non-refresh cycles", 8'(init_done), 8'h0);
        ras_only(4'h2);
        chk("R2", "init after first refresh", 8'(init_done), 8'h1);
    endtask

    task automatic t_basic();
        wr_cycle(4'h2, 4'h6, 4'h9);
        wr_cycle(4'h2, 4'h7, 4'h3);
        rd_cycle(4'h2, 4'h6, 1'b1, 4'h9, "R4");
        rd_cycle(4'h2, 4'h7, 1'b1, 4'h3, "R4");
        // output enable high: no data
        ras_open(4'h2);
        addr = 4'h6; cas_n = 1'b0;
        tick();
        chk("R4", "valid with oe_n high", 8'({dq_valid, dq_out}), 8'h00);
        cas_n = 1'b1;
        tick();
        ras_close();
    endtask

    task automatic t_init_ignore();
        do_reset();
        wr_cycle(4'h2, 4'h6, 4'hA);
        for (int i = 0; i < 6; i++) begin
            rd_cycle(4'h2, 4'h6, 1'b0, 4'h0, "R3");
        end
        chk("R2", "init after 7 cycles", 8'(init_done), 8'h0);
        cbr(1'b1, 4'h5);
        chk("R2", "init after 8th cycle (refresh)", 8'(init_done), 8'h1);
        rd_cycle(4'h2, 4'h6, 1'b1, 4'h9, "R3");
    endtask

    task automatic t_page();
        ras_open(4'h5);
        cas_wr(4'h0, 4'h1);
        cas_wr(4'h9, 4'hC);
        cas_rd(4'h0, 1'b1, 4'h1, "R5");
        cas_rd(4'h9, 1'b1, 4'hC, "R5");
        ras_close();
        rd_cycle(4'h5, 4'h9, 1'b1, 4'hC, "R5");
    endtask

    task automatic t_rmw();
        wr_cycle(4'h7, 4'h3, 4'h5);
        ras_open(4'h7);
        addr = 4'h3; oe_n = 1'b0; cas_n = 1'b0;
        tick();
        chk("R6", "rmw read valid", 8'(dq_valid), 8'h1);
        chk("R6", "rmw old data", 8'(dq_out), 8'h5);
        oe_n = 1'b1; dq_in = 4'hE; we_n = 1'b0;
        tick();
        chk("R6", "no valid during write phase", 8'(dq_valid), 8'h0);
        we_n = 1'b1; cas_n = 1'b1;
        tick();
        ras_close();
        rd_cycle(4'h7, 4'h3, 1'b1, 4'hE, "R6");
    endtask

    task automatic t_cbr_refresh();
        cbr(1'b1, 4'h7);
        rd_cycle(4'h7, 4'h3, 1'b1, 4'hE, "R11");
        rd_cycle(4'h2, 4'h6, 1'b1, 4'h9, "R11");
    endtask

    task automatic t_test_mode();
        wr_cycle(4'h3, 4'h4, 4'h6);
        wr_cycle(4'h3, 4'h5, 4'hF);
        cbr(1'b0, 4'h3);
        rd_cycle(4'h3, 4'h4, 1'b1, 4'h0, "R7");
        wr_cycle(4'h3, 4'h5, 4'b1110);
        rd_cycle(4'h3, 4'h4, 1'b1, 4'hF, "R9");
        wr_cycle(4'h3, 4'h4, 4'b0001);
        rd_cycle(4'h3, 4'h5, 1'b1, 4'hF, "R9");
        ras_only(4'h3);
        rd_cycle(4'h3, 4'h4, 1'b1, 4'hF, "R8");
        rd_cycle(4'h3, 4'h5, 1'b1, 4'hF, "R8");
        wr_cycle(4'h3, 4'h4, 4'h0);
        cbr(1'b0, 4'h9);
        rd_cycle(4'h3, 4'h5, 1'b1, 4'h0, "R9");
        cbr(1'b1, 4'h1);
        rd_cycle(4'h3, 4'h4, 1'b1, 4'h0, "R10");
        rd_cycle(4'h3, 4'h5, 1'b1, 4'hF, "R10");
        rd_cycle(4'h2, 4'h7, 1'b1, 4'h3, "R7");
    endtask

    initial begin
        t_reset();
        bring_up();
        t_init_no_refresh();
        t_basic();
        t_init_ignore();
        t_page();
        t_rmw();
        t_cbr_refresh();
        t_test_mode();
        report();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule